// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Vector Unit

This unit sits beside an I2C bit engine and turns the engine's single-cycle event pulses into software-visible state. Each pulse latches into a sticky status register. Software acknowledges any subset of these flags by writing ones to the status register. An enable register selects which flags drive the single interrupt line. The bus-busy bit is not latched: it always shows the live level from the engine.

For older software there is a second way to see the same events. Reading the vector register returns a small code for the most urgent enabled event, and that read acknowledges the event it reported. Writes to the vector address do not touch the vector. They fill a wakeup-enable register, which is read back at a separate address. All access goes through a plain register port with a combinational read path. Reads have a side effect only at the vector address.

Top module: `i2cev_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and wakeup registers are zero, `irq_o` is low and the vector reads 0.
- R2: A pulse on `evt_i` at a latchable bit sets that status bit from the next cycle on, and the bit stays set until it is cleared. The latchable bits are 14 (transmit drain), 13 (receive drain), 11 (receive overrun), 10 (transmit underflow), 9 (addressed as slave), 8 (address zero), 4 (transmit ready), 3 (receive ready), 2 (access ready), 1 (no acknowledge) and 0 (arbitration lost). Bits 15 and 7..5 always read 0.
- R3: Status bit 12 always reads the current `bus_busy_i`. Writes to it have no effect.
- R4: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When an event pulse and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R6: The enable register is at address 1. Only bits 14, 13, 4, 3, 2, 1 and 0 are stored; all other bits read 0.
- R7: `irq_o` is high exactly when status AND enable is nonzero. It is computed from registered state, so it rises one cycle after the event or enable write that causes it.
- R8: A read at address 2 returns the vector code in bits 2..0, with the upper bits 0. Only status bits 4..0 that are enabled take part. The codes are: 1 for bit 0, 2 for bit 1, 3 for bit 2, 4 for bit 3 and 5 for bit 4. The smallest code wins, and 0 means nothing is pending.
- R9: A read strobe at address 2 clears only the status bit behind the returned code. A read that returns 0 changes nothing.
- R10: A write to address 2 stores the wakeup enable, masked to bits 14, 13, 9, 8, 6, 5, 3, 2, 1 and 0. The wakeup enable reads back at address 3, and the write does not change the vector.
- R11: Addresses 4 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 16 | One-cycle event pulses from the bit engine, in status bit positions |
| bus_busy_i | input | 1 | Live bus-busy level |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect only at the vector address) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The bound checker checks these properties on every cycle:
- an event pulse always wins over a same-cycle clear;
- a written one removes a flag, and a flag is never lost without an acknowledge;
- bus busy on the read port matches the input;
- the vector and wakeup views never show bits outside their ranges;
- the interrupt only rises after an event or a register write.

Three things only the bench's scenarios can show: the vector's priority order, the single-bit acknowledge on a vector read, and the masking of the enable register. The bench shows them through a behavioural model that is compared with `rdata_o` and `irq_o` on every clock, both in directed sequences and in a random one.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
  localparam int REG_W = 16;
  // status bits that latch event pulses
  localparam logic [REG_W-1:0] LATCH_MASK  = 16'h6F1F;
  // bits that can raise the interrupt
  localparam logic [REG_W-1:0] IRQ_EN_MASK = 16'h601F;
  // stored bits of the wakeup enable
  localparam logic [REG_W-1:0] WAKE_MASK   = 16'h636F;
  localparam int BUSY_BIT = 12;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_WAKE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2cev_rst_sync.sv
module i2cev_rst_sync (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/i2cev_stat_reg.sv
module i2cev_stat_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] stat_nxt;
  logic         stat_en;

  // set has priority over clear for the same bit
  always_comb begin
    stat_nxt = ((stat_q & ~clr_i) | evt_i) & MASK;
    stat_en  = |((evt_i | clr_i) & MASK);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end
endmodule

// File: rtl/i2cev_cfg_regs.sv
module i2cev_cfg_regs #(
  parameter int W = 16,
  parameter logic [W-1:0] IEN_MASK  = '1,
  parameter logic [W-1:0] WAKE_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         ien_we_i,
  input  logic         wake_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ien_q,
  output logic [W-1:0] wake_q
);
  logic [W-1:0] ien_nxt, wake_nxt;

  always_comb begin
    ien_nxt  = wdata_i & IEN_MASK;
    wake_nxt = wdata_i & WAKE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ien_q  <= '0;
      wake_q <= '0;
    end else begin
      if (ien_we_i)  ien_q  <= ien_nxt;
      if (wake_we_i) wake_q <= wake_nxt;
    end
  end
endmodule

// File: rtl/i2cev_vec_enc.sv
module i2cev_vec_enc #(
  parameter int N  = 5,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  hit_o,
  output logic [CW-1:0] code_o
);
  logic [N-1:0] lower;

  assign lower[0] = 1'b0;

  // lowest index wins: a bit is hit only if nothing below it is pending
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign hit_o[i] = pend_i[i] & ~lower[i];
    if (i + 1 < N) begin : g_chain
      assign lower[i+1] = lower[i] | pend_i[i];
    end
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_o[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2cev_irq_ctrl.sv
module i2cev_irq_ctrl
  import i2cev_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_VEC = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [REG_W-1:0]  evt_i,
  input  logic              bus_busy_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int CODE_W = $clog2(NUM_VEC + 1);

  logic              rst_n_s;
  logic              in_map;
  reg_sel_e          sel;
  logic              wr_stat, wr_ien, wr_wake, rd_vec;
  logic [REG_W-1:0]  stat_q, ien_q, wake_q, clr;
  logic [NUM_VEC-1:0] pend, hit;
  logic [CODE_W-1:0] code;

  i2cev_rst_sync u_rst (
    .clk_i    (clk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_n_s)
  );

  // address decode
  always_comb begin
    in_map  = (addr_i >> 2) == '0;
    sel     = reg_sel_e'(addr_i[1:0]);
    wr_stat = wr_en_i & in_map & (sel == SEL_STAT);
    wr_ien  = wr_en_i & in_map & (sel == SEL_IEN);
    wr_wake = wr_en_i & in_map & (sel == SEL_VEC);
    rd_vec  = rd_en_i & in_map & (sel == SEL_VEC);
  end

  assign pend = stat_q[NUM_VEC-1:0] & ien_q[NUM_VEC-1:0];

  i2cev_vec_enc #(.N(NUM_VEC), .CW(CODE_W)) u_vec (
    .pend_i (pend),
    .hit_o  (hit),
    .code_o (code)
  );

  always_comb begin
    clr = '0;
    if (wr_stat) clr = clr | wdata_i;
    if (rd_vec)  clr = clr | {{(REG_W-NUM_VEC){1'b0}}, hit};
  end

  i2cev_stat_reg #(.W(REG_W), .MASK(LATCH_MASK)) u_stat (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_s),
    .evt_i   (evt_i),
    .clr_i   (clr),
    .stat_q  (stat_q)
  );

  i2cev_cfg_regs #(.W(REG_W), .IEN_MASK(IRQ_EN_MASK), .WAKE_MASK(WAKE_MASK)) u_cfg (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_s),
    .ien_we_i  (wr_ien),
    .wake_we_i (wr_wake),
    .wdata_i   (wdata_i),
    .ien_q     (ien_q),
    .wake_q    (wake_q)
  );

  assign irq_o = |(stat_q & ien_q);

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      case (sel)
        SEL_STAT: begin
          rdata_o           = stat_q;
          rdata_o[BUSY_BIT] = bus_busy_i;
        end
        SEL_IEN:  rdata_o = ien_q;
        SEL_VEC:  rdata_o = {{(REG_W-CODE_W){1'b0}}, code};
        default:  rdata_o = wake_q;
      endcase
    end
  end
endmodule

// File: rtl/i2cev_irq_chk.sv
module i2cev_irq_chk #(
  parameter int ADDR_W  = 3,
  parameter int NUM_VEC = 5
) (
  input logic              clk_i,
  input logic              rst_n_s,
  input logic [15:0]       evt_i,
  input logic              bus_busy_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic              irq_o,
  input logic [15:0]       stat_q
);
  // R5
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    evt_i[0] |=> stat_q[0]);

  // R4
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (wr_en_i && addr_i == '0 && wdata_i[3] && !evt_i[3]) |=> !stat_q[3]);

  // R2
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (stat_q[9] && !(wr_en_i && addr_i == '0 && wdata_i[9])) |=> stat_q[9]);

  // R3
  busy_live_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (addr_i == '0) |-> (rdata_o[12] == bus_busy_i));

  // R8
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (addr_i == ADDR_W'(2)) |-> (rdata_o <= 16'(NUM_VEC)));

  // R7
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    $rose(irq_o) |-> $past(evt_i != '0 || wr_en_i));

  // R10
  wake_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (addr_i == ADDR_W'(3)) |-> ((rdata_o & ~16'h636F) == '0));
endmodule

bind i2cev_irq_ctrl i2cev_irq_chk #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_chk (
  .clk_i      (clk_i),
  .rst_n_s    (rst_n_s),
  .evt_i      (evt_i),
  .bus_busy_i (bus_busy_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .stat_q     (stat_q)
);

// File: tb/test_i2cev_irq_ctrl.sv
`timescale 1ns/1ps
module test_i2cev_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] evt;
  logic        busy;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // behavioural model state
  int m_stat = 0, m_ien = 0, m_wake = 0;

  always #2 clk = ~clk;

  i2cev_irq_ctrl i_i2cev_irq_ctrl (
    .clk_i(clk), .rst_n_i(rst_n), .evt_i(evt), .bus_busy_i(busy),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int m_code();
    int p = m_stat & m_ien & 'h1F;
    for (int i = 0; i < 5; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  function automatic int m_rdata(int a, bit bb);
    case (a)
      0: return (m_stat & 'hEFFF) | (bb ? 'h1000 : 0);
      1: return m_ien;
      2: return m_code();
      3: return m_wake;
      default: return 0;
    endcase
  endfunction

  task automatic step(input logic [15:0] ev, input logic bb, input logic wr,
                      input logic rd, input logic [2:0] ad, input logic [15:0] wd,
                      input string tag);
    int exp_d;
    bit exp_i;
    int clr;
    int c;
    @(negedge clk);
    evt = ev; busy = bb; wr_en = wr; rd_en = rd; addr = ad; wdata = wd;
    #1;
    exp_d = m_rdata(int'(ad), bb);
    exp_i = (m_stat & m_ien) != 0;
    tests++;
    if (rdata !== 16'(exp_d) || irq !== exp_i) begin
      fails++;
      $display("FAIL %s: rdata=%h exp=%h irq=%b exp=%b", tag, rdata, 16'(exp_d), irq, exp_i);
    end
    @(posedge clk);
    clr = 0;
    c = m_code();
    if (wr && ad == 0) clr = int'(wd);
    if (rd && ad == 2 && c != 0) clr = clr | (1 << (c - 1));
    m_stat = ((m_stat & ~clr) | int'(ev)) & 'h6F1F;
    if (wr && ad == 1) m_ien  = int'(wd) & 'h601F;
    if (wr && ad == 2) m_wake = int'(wd) & 'h636F;
  endtask

  task automatic rd_chk(input logic [2:0] ad, input string tag);
    step(16'h0, 1'b0, 1'b0, 1'b0, ad, 16'h0, tag);
  endtask

  task automatic wr_chk(input logic [2:0] ad, input logic [15:0] wd, input string tag);
    step(16'h0, 1'b0, 1'b1, 1'b0, ad, wd, tag);
  endtask

  task automatic vec_rd(input string tag);
    step(16'h0, 1'b0, 1'b0, 1'b1, 3'd2, 16'h0, tag);
  endtask

  task automatic ev_pulse(input logic [15:0] ev, input string tag);
    step(ev, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; busy = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state of every view
    for (int a = 0; a < 4; a++) rd_chk(3'(a), "R1 reset");

    // R6 enable masking
    wr_chk(3'd1, 16'hFFFF, "R6 enable write");
    rd_chk(3'd1, "R6 enable readback");

    // R2 every bit position, latchable or not
    for (int b = 0; b < 16; b++) begin
      ev_pulse(16'(1 << b), "R2 event pulse");
      rd_chk(3'd0, "R2 status after pulse");
      rd_chk(3'd0, "R2 status held");
    end
    wr_chk(3'd0, 16'hFFFF, "R4 clear all");
    rd_chk(3'd0, "R4 cleared");

    // R3 live busy, write ignored
    step(16'h0, 1'b1, 1'b0, 1'b0, 3'd0, 16'h0, "R3 busy high");
    step(16'h0, 1'b1, 1'b1, 1'b0, 3'd0, 16'h1000, "R3 write busy bit");
    step(16'h0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "R3 busy low");

    // R4 subset clear
    ev_pulse(16'h0007, "R4 set three");
    wr_chk(3'd0, 16'h0002, "R4 clear one");
    rd_chk(3'd0, "R4 two remain");
    wr_chk(3'd0, 16'h0000, "R4 zero write");
    rd_chk(3'd0, "R4 zero has no effect");
    wr_chk(3'd0, 16'hFFFF, "R4 clear all");

    // R5 set beats clear
    step(16'h0008, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0008, "R5 set and clear");
    rd_chk(3'd0, "R5 bit kept");
    wr_chk(3'd0, 16'hFFFF, "R4 clear all");

    // R7 masking of the interrupt line
    wr_chk(3'd1, 16'h0000, "R7 disable all");
    ev_pulse(16'h0010, "R7 masked event");
    rd_chk(3'd0, "R7 irq stays low");
    wr_chk(3'd1, 16'h0010, "R7 enable bit4");
    rd_chk(3'd0, "R7 irq high");
    wr_chk(3'd0, 16'h0010, "R7 ack");
    rd_chk(3'd0, "R7 irq low again");
    ev_pulse(16'h4000, "R7 drain event");
    rd_chk(3'd0, "R7 drain masked");

    // R8 priority and R9 read-clear
    wr_chk(3'd1, 16'h001F, "R8 enable vector bits");
    ev_pulse(16'h001C, "R8 three events");
    vec_rd("R8 R9 vector read 3");
    vec_rd("R8 R9 vector read 4");
    rd_chk(3'd0, "R9 only reported bit cleared");
    vec_rd("R8 R9 vector read 5");
    vec_rd("R9 empty vector read");
    rd_chk(3'd0, "R9 empty read changes nothing");
    ev_pulse(16'h0013, "R8 arb nack tx");
    rd_chk(3'd2, "R8 arb lost first");
    wr_chk(3'd1, 16'h0012, "R8 disable arb");
    rd_chk(3'd2, "R8 disabled bit skipped");
    rd_chk(3'd0, "R8 status unchanged by plain read");
    wr_chk(3'd0, 16'hFFFF, "R4 clear all");

    // R10 wakeup register shares the vector address
    ev_pulse(16'h0004, "R10 pending event");
    wr_chk(3'd2, 16'hFFFF, "R10 wakeup write");
    rd_chk(3'd3, "R10 wakeup readback");
    rd_chk(3'd2, "R10 vector untouched");
    rd_chk(3'd0, "R10 status untouched");

    // R11 unmapped addresses
    for (int a = 4; a < 8; a++) begin
      wr_chk(3'(a), 16'hFFFF, "R11 unmapped write");
      rd_chk(3'(a), "R11 unmapped read");
    end
    rd_chk(3'd1, "R11 enable unchanged");
    rd_chk(3'd0, "R11 status unchanged");

    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [15:0] ev;
      ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
      step(ev, 1'($urandom), 1'(($urandom % 4) == 0), 1'($urandom),
           3'($urandom), 16'($urandom), "R2 R4 R7 R8 R9 random");
    end
    step(16'h0, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, "R2 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule